// File: doc/BRIEF.md
# Multi-Channel Timer Register Front-End

This block puts two or three down-counting timer channels behind one byte-addressed, word-wide register window. A shared start register holds one run bit per channel. An optional output-control register holds one stored bit. Each channel owns a bank of registers at a fixed base offset: a reload constant, a live counter and a control/status word. The third channel also has a capture register.

While its run bit is set, a channel counts down once per clock. When it passes zero it reloads and raises an underflow flag. The flag, gated by the channel's interrupt enable, drives that channel's own interrupt line.

Build parameters choose whether the third channel exists, whether the output-control register exists, and whether the external-clock edge field of the control word can be written. Every access takes one cycle. Read data and an error pulse are registered. Accesses that hit nothing read as zero, leave all state unchanged, and raise the error pulse.

Top module: `tmr_unit`

## Requirements
- R1: After reset the run register, every control word, the output-control bit and the capture register read 0, every reload constant and counter reads 0xFFFFFFFF, and all interrupt lines are low.
- R2: Byte offset 0x00 is the output-control register when OUT_CTL=1: only bit 0 is stored and bits 31:1 read 0. When OUT_CTL=0 the offset is unmapped (R8).
- R3: Offset 0x04 is the run register. Bit n runs channel n. Reads return the last written value masked to the implemented channel bits (bits 2:0 with three channels, bits 1:0 otherwise).
- R4: With THREE_CH=0, a write to 0x04 with bit 2 set raises the error pulse. Bit 2 is not stored, and bits 1:0 are still applied.
- R5: Channel banks start at 0x08, 0x14 and 0x20, with bank 2 present only when THREE_CH=1. Within a bank, local offset 0x0 is the reload constant, 0x4 the counter, 0x8 the control word, and 0xC (bank 2 only, at 0x2C) the capture register.
- R6: While running, a channel's counter drops by one per clock. A clock at which it holds zero instead loads the reload constant and sets the underflow flag. A bus write to the counter takes priority over counting.
- R7: Control bit 8 is the underflow flag and bit 5 the interrupt enable. irq[n] is high while both are set. Writing 0 to bit 8 clears the flag, and writing 1 to bit 8 leaves it unchanged.
- R8: A read or write to an unmapped or non-word-aligned offset returns 0, changes no state, and raises err for one cycle.
- R9: rdata and err appear in the cycle after the request. rdata is 0 whenever the previous cycle held no valid read.
- R10: Control bits 2:0 and 5 are always stored. Bits 4:3 are stored only when EXT_CLK=1. Bits 7:6 are stored only in channel 2. All other control bits except the flag read 0.
- R11: A stopped channel holds its count. With THREE_CH=0, irq[2] stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte offset of the word accessed |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| err | output | 1 | One-cycle pulse for an invalid access |
| irq | output | 3 | One interrupt line per channel |

## Verification
The bench drives the counter across zero with an exact number of run cycles. A design that miscounts the reload step, or that reloads from the wrong register, leaves a different count and flag state. It writes 1 and then 0 into the flag bit, which catches a flag that a 1 sets or that a 0 fails to clear. It also probes both ends of every bank, misaligned offsets and offsets past the last bank. This exposes decoders whose bank edges are off by one word, or that let a stray write land in a neighbouring bank. A second build without the third channel and output-control register checks that start bit 2 is rejected with an error, and that the missing offsets read zero.

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit #(
  parameter bit THREE_CH = 1'b1,
  parameter bit OUT_CTL  = 1'b1,
  parameter bit EXT_CLK  = 1'b0,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [2:0]    irq
);
  localparam int       NCH      = THREE_CH ? 3 : 2;
  localparam logic [2:0] RUN_MASK = THREE_CH ? 3'b111 : 3'b011;

  logic          wr, rd, aligned, hit_oc, hit_run, valid, bad_run;
  logic          oc_q;
  logic [2:0]    run_q;
  logic [2:0]    hit, irq_w;
  logic [DW-1:0] rv [3];
  logic [DW-1:0] rd_val, rdata_q;
  logic          err_q;

  assign wr      = req & we;
  assign rd      = req & ~we;
  assign aligned = addr[1:0] == 2'b00;
  assign hit_oc  = OUT_CTL && (addr == '0);
  assign hit_run = addr == AW'(4);

  for (genvar i = 0; i < 3; i++) begin : g_ch
    if (i < NCH) begin : g_on
      localparam logic [AW-1:0] BASE = AW'(8 + 12 * i);
      localparam logic [AW-1:0] TOP  = AW'(8 + 12 * i + ((i == 2) ? 16 : 12));
      localparam logic [7:0]    MASK = 8'h27 | (EXT_CLK ? 8'h18 : 8'h00)
                                     | ((i == 2) ? 8'hC0 : 8'h00);
      logic [3:0]    lo;
      logic [DW-1:0] cor_q, cnt_q, cap_q;
      logic [7:0]    ctl_q;
      logic          uf_q, wcor, wcnt, wctl, fire;

      assign lo     = 4'(addr - BASE);
      assign hit[i] = aligned && (addr >= BASE) && (addr < TOP);
      assign wcor   = wr && hit[i] && lo[3:2] == 2'd0;
      assign wcnt   = wr && hit[i] && lo[3:2] == 2'd1;
      assign wctl   = wr && hit[i] && lo[3:2] == 2'd2;
      assign fire   = run_q[i] && !wcnt && (cnt_q == '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cor_q <= '1;
          cnt_q <= '1;
          ctl_q <= '0;
          uf_q  <= 1'b0;
        end else begin
          if (wcor) cor_q <= wdata;
          if (wcnt)          cnt_q <= wdata;
          else if (fire)     cnt_q <= cor_q;
          else if (run_q[i]) cnt_q <= cnt_q - 1'b1;
          if (wctl) ctl_q <= wdata[7:0] & MASK;
          uf_q <= (uf_q & ~(wctl & ~wdata[8])) | fire;
        end
      end

      if (i == 2) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) cap_q <= '0;
          else if (wr && hit[i] && lo[3:2] == 2'd3) cap_q <= wdata;
        end
      end else begin : g_nocap
        assign cap_q = '0;
      end

      always_comb begin
        case (lo[3:2])
          2'd0:    rv[i] = cor_q;
          2'd1:    rv[i] = cnt_q;
          2'd2:    rv[i] = DW'({uf_q, ctl_q});
          default: rv[i] = cap_q;
        endcase
      end

      assign irq_w[i] = uf_q & ctl_q[5];
    end else begin : g_off
      assign hit[i]   = 1'b0;
      assign rv[i]    = '0;
      assign irq_w[i] = 1'b0;
    end
  end

  assign valid   = aligned && (hit_oc || hit_run || (|hit));
  assign bad_run = wr && hit_run && !THREE_CH && wdata[2];

  always_comb begin
    rd_val = '0;
    if (hit_oc)  rd_val[0]   = oc_q;
    if (hit_run) rd_val[2:0] = run_q;
    for (int i = 0; i < 3; i++)
      if (hit[i]) rd_val = rd_val | rv[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q    <= 1'b0;
      run_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr && hit_oc)  oc_q  <= wdata[0];
      if (wr && hit_run) run_q <= wdata[2:0] & RUN_MASK;
      rdata_q <= (rd && valid) ? rd_val : '0;
      err_q   <= req && (!valid || bad_run);
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
  assign irq   = irq_w;
endmodule

// File: rtl/tmr_unit_chk.sv
`timescale 1ns/1ps
module tmr_unit_chk #(
  parameter bit THREE_CH = 1'b1,
  parameter int DW       = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic [DW-1:0] rdata,
  input logic          err,
  input logic [2:0]    irq,
  input logic [2:0]    run_q
);
  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req)); // R8

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdata == '0); // R8

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req && !we) |-> rdata == '0); // R9

  AST_IRQ_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq) & ~irq) != 3'b000) |-> $past(req && we)); // R7

  AST_NO_RUN_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
    !THREE_CH |-> !run_q[2]); // R4

  AST_IRQ2_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    !THREE_CH |-> !irq[2]); // R11
endmodule

bind tmr_unit tmr_unit_chk #(.THREE_CH(THREE_CH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we),
  .rdata(rdata), .err(err), .irq(irq), .run_q(run_q)
);

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req0 = 1'b0, req1 = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        err0, err1;
  logic [2:0]  irq0, irq1;
  int          errors = 0, checks = 0;
  logic        acc0 = 1'b0, acc1 = 1'b0;
  bit          done = 1'b0;

  typedef struct {
    bit          dut;
    logic [31:0] d;
    logic        e;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  tmr_unit u0 (.clk(clk), .rst_n(rst_n), .req(req0), .we(we), .addr(addr),
               .wdata(wdata), .rdata(rdata0), .err(err0), .irq(irq0));

  tmr_unit #(.THREE_CH(1'b0), .OUT_CTL(1'b0), .EXT_CLK(1'b1)) u1 (
               .clk(clk), .rst_n(rst_n), .req(req1), .we(we), .addr(addr),
               .wdata(wdata), .rdata(rdata1), .err(err1), .irq(irq1));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    acc0 <= req0;
    acc1 <= req1;
  end

  always @(negedge clk) begin
    if ((acc0 || acc1) && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.dut ? rdata1 : rdata0, it.d, {it.tag, " rdata"});
      chk({31'b0, it.dut ? err1 : err0}, {31'b0, it.e}, {it.tag, " err"});
    end
  end

  task automatic acc(input bit dut, input bit w, input logic [7:0] a,
                     input logic [31:0] wd, input logic [31:0] ed,
                     input logic ee, input string tag);
    item_t it;
    @(negedge clk);
    it.dut = dut; it.d = w ? 32'h0 : ed; it.e = ee; it.tag = tag;
    sb.push_back(it);
    we = w; addr = a; wdata = wd;
    if (dut) req1 = 1'b1; else req0 = 1'b1;
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk({29'b0, irq0}, 32'h0, "R1 irq after reset");
    acc(0, 0, 8'h04, 0, 32'h0, 0, "R1 run reg");
    acc(0, 0, 8'h10, 0, 32'h0, 0, "R1 ctl0");
    acc(0, 0, 8'h08, 0, 32'hFFFFFFFF, 0, "R1 cor0");
    acc(0, 0, 8'h0C, 0, 32'hFFFFFFFF, 0, "R1 cnt0");
    acc(0, 0, 8'h00, 0, 32'h0, 0, "R1 outctl");
    acc(0, 0, 8'h2C, 0, 32'h0, 0, "R1 capture");
    // R2 output control
    acc(0, 1, 8'h00, 32'hFFFFFFFF, 0, 0, "R2 write outctl");
    acc(0, 0, 8'h00, 0, 32'h1, 0, "R2 outctl bit0 only");
    // R3 run register
    acc(0, 1, 8'h04, 32'hFF, 0, 0, "R3 write run");
    acc(0, 0, 8'h04, 0, 32'h7, 0, "R3 run masked");
    acc(0, 1, 8'h04, 32'h0, 0, 0, "R3 stop all");
    // R5 bank offsets
    acc(0, 1, 8'h08, 32'h55, 0, 0, "R5 w cor0");
    acc(0, 1, 8'h14, 32'h1234, 0, 0, "R5 w cor1");
    acc(0, 1, 8'h20, 32'hABCD, 0, 0, "R5 w cor2");
    acc(0, 1, 8'h2C, 32'hCAFE, 0, 0, "R5 w cap2");
    acc(0, 0, 8'h08, 0, 32'h55, 0, "R5 cor0");
    acc(0, 0, 8'h14, 0, 32'h1234, 0, "R5 cor1");
    acc(0, 0, 8'h20, 0, 32'hABCD, 0, "R5 cor2");
    acc(0, 0, 8'h2C, 0, 32'hCAFE, 0, "R5 cap2");
    // R10 control masks
    acc(0, 1, 8'h10, 32'hFFFFFFFF, 0, 0, "R10 w ctl0");
    acc(0, 0, 8'h10, 0, 32'h27, 0, "R10 ctl0 mask");
    acc(0, 1, 8'h28, 32'hFF, 0, 0, "R10 w ctl2");
    acc(0, 0, 8'h28, 0, 32'hE7, 0, "R10 ctl2 mask");
    // R6 counting through zero: 6 run clocks from 2 with reload 3 -> 0, flag set
    acc(0, 1, 8'h08, 32'h3, 0, 0, "R6 w cor0");
    acc(0, 1, 8'h0C, 32'h2, 0, 0, "R6 w cnt0");
    acc(0, 1, 8'h10, 32'h20, 0, 0, "R6 w ctl0");
    acc(0, 1, 8'h04, 32'h1, 0, 0, "R6 start ch0");
    idle(4);
    acc(0, 1, 8'h04, 32'h0, 0, 0, "R6 stop ch0");
    acc(0, 0, 8'h0C, 0, 32'h0, 0, "R6 cnt0 after run");
    acc(0, 0, 8'h10, 0, 32'h120, 0, "R6 flag set");
    chk({29'b0, irq0}, 32'h1, "R7 irq0 raised");
    // R7 flag clear rule
    acc(0, 1, 8'h10, 32'h120, 0, 0, "R7 write flag one");
    acc(0, 0, 8'h10, 0, 32'h120, 0, "R7 flag kept");
    chk({29'b0, irq0}, 32'h1, "R7 irq0 kept");
    acc(0, 1, 8'h10, 32'h020, 0, 0, "R7 write flag zero");
    acc(0, 0, 8'h10, 0, 32'h020, 0, "R7 flag cleared");
    chk({29'b0, irq0}, 32'h0, "R7 irq0 cleared");
    // R11 stopped channel holds
    idle(5);
    acc(0, 0, 8'h0C, 0, 32'h0, 0, "R11 cnt0 held");
    // R6 channel 2: 2 run clocks from 0 with reload 1 -> 0, flag set
    acc(0, 1, 8'h20, 32'h1, 0, 0, "R6 w cor2");
    acc(0, 1, 8'h24, 32'h0, 0, 0, "R6 w cnt2");
    acc(0, 1, 8'h28, 32'h20, 0, 0, "R6 w ctl2");
    acc(0, 1, 8'h04, 32'h4, 0, 0, "R3 start ch2");
    acc(0, 1, 8'h04, 32'h0, 0, 0, "R3 stop ch2");
    acc(0, 0, 8'h24, 0, 32'h0, 0, "R6 cnt2");
    acc(0, 0, 8'h28, 0, 32'h120, 0, "R6 flag2");
    chk({29'b0, irq0}, 32'h4, "R7 irq2 only");
    acc(0, 1, 8'h28, 32'h0, 0, 0, "R7 clear ctl2");
    chk({29'b0, irq0}, 32'h0, "R7 irq2 cleared");
    // R8 bad accesses
    acc(0, 0, 8'h30, 0, 32'h0, 1, "R8 read past banks");
    acc(0, 1, 8'h30, 32'h99, 0, 1, "R8 write past banks");
    acc(0, 0, 8'h09, 0, 32'h0, 1, "R8 misaligned read");
    acc(0, 1, 8'h0D, 32'h77, 0, 1, "R8 misaligned write");
    acc(0, 0, 8'h0C, 0, 32'h0, 0, "R8 cnt0 untouched");
    acc(0, 0, 8'hFC, 0, 32'h0, 1, "R8 top offset");
    // R9 idle output
    idle(1);
    chk(rdata0, 32'h0, "R9 rdata idle");
    // second build: two channels, no output control, external clock field
    acc(1, 1, 8'h00, 32'h1, 0, 1, "R2 outctl absent write");
    acc(1, 0, 8'h00, 0, 32'h0, 1, "R2 outctl absent read");
    acc(1, 1, 8'h04, 32'h7, 0, 1, "R4 bit2 error");
    acc(1, 0, 8'h04, 0, 32'h3, 0, "R4 bits1:0 applied");
    chk({31'b0, irq1[2]}, 32'h0, "R11 irq2 low");
    acc(1, 1, 8'h04, 32'h0, 0, 0, "R3 stop u1");
    acc(1, 0, 8'h20, 0, 32'h0, 1, "R5 bank2 absent");
    acc(1, 1, 8'h2C, 32'h5, 0, 1, "R8 cap absent write");
    acc(1, 0, 8'h2C, 0, 32'h0, 1, "R8 cap absent read");
    acc(1, 1, 8'h10, 32'hFF, 0, 0, "R10 w ctl0 ext");
    acc(1, 0, 8'h10, 0, 32'h3F, 0, "R10 ext field stored");
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule